// File: doc/BRIEF.md
# Packed Multiply and Absolute-Difference Unit

This block is a 64-bit packed-integer arithmetic stage. It treats each operand as four 16-bit lanes, or as eight 8-bit lanes for one operation. A 4-bit operation code selects one of ten functions:

- per-lane multiplies that keep either the low or the high half of each product;
- pairwise multiply-add into two 32-bit halves;
- a four-lane multiply-accumulate reduction;
- a sum of absolute differences over byte lanes or over halfword lanes.

All multiply functions share one set of four 16x16 multiplier lanes. A signed/unsigned control on those lanes picks how each lane operand is extended.

The operands and the operation code are captured on a clock edge where `in_valid` is high. The result is then presented with `out_valid` high for the following cycle. The result stays constant until the next capture. There is no saturation, no accumulator storage and no flag output.

Top module: `pmul_sad_unit`

## Requirements
- R1: A capture (`in_valid` high at a rising edge) makes `out_valid` high for exactly the next cycle. `out_valid` is low after any edge where `in_valid` was low, and `result` does not change unless a capture occurs.
- R2: While `rst_n` is low at a rising edge, `out_valid` is low after that edge, whatever `in_valid` is.
- R3: Codes 0 (signed) and 2 (unsigned) multiply lane i of A by lane i of B, for the four 16-bit lanes at bits [16i+15:16i]. Each result lane holds product bits [15:0].
- R4: Codes 1 (signed) and 3 (unsigned) do the same lane multiplies, but each result lane holds product bits [31:16].
- R5: Codes 4 (signed) and 5 (unsigned) place the low 32 bits of lane0·lane0 + lane1·lane1 in result[31:0]. They place the low 32 bits of lane2·lane2 + lane3·lane3 in result[63:32].
- R6: Code 6 adds the four signed lane products at full precision and returns the sum sign-extended to 64 bits.
- R7: Code 7 adds the four unsigned lane products and returns the sum zero-extended to 64 bits.
- R8: Code 8 returns the zero-extended sum of |A_byte − B_byte| over all eight unsigned byte lanes.
- R9: Code 9 returns the zero-extended sum of |A_half − B_half| over the four unsigned 16-bit lanes.
- R10: Codes 10 to 15 return a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the operands and the operation code |
| op_code | input | 4 | Operation select, 0 to 9 defined |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| out_valid | output | 1 | High in the cycle after a capture |
| result | output | 64 | Packed or reduced result of the last captured operation |

## Verification
The bench drives lanes of 0x8000 and 0xFFFF through every code, where signed and unsigned readings differ most. A design that extends the lane operands wrongly gives the wrong sign or magnitude in the high-half and accumulate results. The product 0x8000·0x8000 is used to expose a high-half multiply that drops the top product bit. The signed reduction is run with negative sums so that a missing sign extension leaves zeros in the upper word. The absolute-difference cases put the larger operand on either side, so a one-directional subtract wraps and is caught. Unused codes, the valid timing, the result hold between captures and reset during a strobe are each checked directly.

// File: rtl/pmul_pkg.sv
// Shared constants and operation encodings for the packed multiply unit.
// Assumes a datapath that is a whole multiple of the 16-bit lane width.
package pmul_pkg;

    localparam int unsigned PM_DATA_W = 64;
    localparam int unsigned PM_LANE_W = 16;

    typedef enum logic [3:0] {
        OP_MULLO_S = 4'd0,
        OP_MULHI_S = 4'd1,
        OP_MULLO_U = 4'd2,
        OP_MULHI_U = 4'd3,
        OP_PAIR_S  = 4'd4,
        OP_PAIR_U  = 4'd5,
        OP_MACC_S  = 4'd6,
        OP_MACC_U  = 4'd7,
        OP_SAD_B   = 4'd8,
        OP_SAD_H   = 4'd9
    } pmul_op_e;

    localparam logic [3:0] OP_LAST = 4'd9;

endpackage

// File: rtl/pmul_lane_mult.sv
// One multiplier lane: W x W product with a signed/unsigned mode.
// Each operand is widened by one bit (sign or zero), so a single signed
// multiplier covers both modes. The output carries two guard bits.
// Assumes the caller picks which product bits to keep.
module pmul_lane_mult #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]          x,
    input  logic [W-1:0]          y,
    input  logic                  sgn,
    output logic signed [2*W+1:0] prod
);
    localparam int unsigned PW = 2 * W + 2;

    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] y_ext;

    // Widen both operands according to the mode, then multiply.
    always_comb begin
        x_ext = {{(PW - W){sgn & x[W-1]}}, x};
        y_ext = {{(PW - W){sgn & y[W-1]}}, y};
        prod  = x_ext * y_ext;
    end

endmodule

// File: rtl/pmul_absdiff_sum.sv
// Sum of absolute differences over LANES unsigned lanes of width LW.
// The sum is wide enough that it never wraps.
// Assumes both vectors are packed lane 0 in the low bits.
module pmul_absdiff_sum #(
    parameter int unsigned LW    = 8,
    parameter int unsigned LANES = 8,
    parameter int unsigned SUM_W = LW + $clog2(LANES)
) (
    input  logic [LW*LANES-1:0] a,
    input  logic [LW*LANES-1:0] b,
    output logic [SUM_W-1:0]    sum
);
    // Form each lane difference in the non-wrapping direction and accumulate.
    always_comb begin
        logic [LW-1:0] da;
        logic [LW-1:0] db;
        logic [LW-1:0] d;
        sum = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            da  = a[i*LW +: LW];
            db  = b[i*LW +: LW];
            d   = (da > db) ? (da - db) : (db - da);
            sum = sum + SUM_W'(d);
        end
    end

endmodule

// File: rtl/pmul_sad_unit.sv
// Packed multiply / absolute-difference unit, top level.
// Operands and operation code are captured when in_valid is high. The result
// is formed from the captured copy and shown with out_valid one cycle later.
// It stays unchanged until the next capture.
// Assumes DATA_W is a multiple of 2*LANE_W and LANE_W is even.
module pmul_sad_unit
    import pmul_pkg::*;
#(
    parameter int unsigned DATA_W = PM_DATA_W,
    parameter int unsigned LANE_W = PM_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned LANES   = DATA_W / LANE_W;
    localparam int unsigned PAIRS   = LANES / 2;
    localparam int unsigned PROD_W  = 2 * LANE_W + 2;
    localparam int unsigned KEEP_W  = 2 * LANE_W;
    localparam int unsigned MACC_W  = PROD_W + $clog2(LANES);
    localparam int unsigned BYTE_W  = LANE_W / 2;
    localparam int unsigned BLANES  = DATA_W / BYTE_W;
    localparam int unsigned SADB_W  = BYTE_W + $clog2(BLANES);
    localparam int unsigned SADH_W  = LANE_W + $clog2(LANES);

    logic [DATA_W-1:0]        a_q;
    logic [DATA_W-1:0]        b_q;
    logic [3:0]               op_q;
    logic                     vld_q;
    logic                     sgn;
    logic signed [PROD_W-1:0] prod [LANES];
    logic [MACC_W-1:0]        macc;
    logic [SADB_W-1:0]        sad_b;
    logic [SADH_W-1:0]        sad_h;

    // Valid pipeline bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_valid;
    end

    // Operand and operation capture on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= '0;
        end else if (in_valid) begin
            a_q  <= src_a;
            b_q  <= src_b;
            op_q <= op_code;
        end
    end

    // Signed mode for the shared multiplier lanes.
    always_comb begin
        sgn = (op_q == OP_MULLO_S) || (op_q == OP_MULHI_S) ||
              (op_q == OP_PAIR_S)  || (op_q == OP_MACC_S);
    end

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            pmul_lane_mult #(.W(LANE_W)) mult_i (
                .x    (a_q[g*LANE_W +: LANE_W]),
                .y    (b_q[g*LANE_W +: LANE_W]),
                .sgn  (sgn),
                .prod (prod[g])
            );
        end
    endgenerate

    pmul_absdiff_sum #(.LW(BYTE_W), .LANES(BLANES), .SUM_W(SADB_W)) sadb_i (
        .a   (a_q),
        .b   (b_q),
        .sum (sad_b)
    );

    pmul_absdiff_sum #(.LW(LANE_W), .LANES(LANES), .SUM_W(SADH_W)) sadh_i (
        .a   (a_q),
        .b   (b_q),
        .sum (sad_h)
    );

    // Full-precision reduction of all lane products (sign carried through).
    always_comb begin
        macc = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            macc = macc + {{(MACC_W - PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    // Result selection by the captured operation code.
    always_comb begin
        result = '0;
        case (op_q)
            OP_MULLO_S, OP_MULLO_U: begin
                for (int i = 0; i < int'(LANES); i++)
                    result[i*LANE_W +: LANE_W] = prod[i][LANE_W-1:0];
            end
            OP_MULHI_S, OP_MULHI_U: begin
                for (int i = 0; i < int'(LANES); i++)
                    result[i*LANE_W +: LANE_W] = prod[i][KEEP_W-1:LANE_W];
            end
            OP_PAIR_S, OP_PAIR_U: begin
                for (int j = 0; j < int'(PAIRS); j++)
                    result[j*KEEP_W +: KEEP_W] = prod[2*j][KEEP_W-1:0] +
                                                 prod[2*j+1][KEEP_W-1:0];
            end
            OP_MACC_S, OP_MACC_U: begin
                result = {{(DATA_W - MACC_W){macc[MACC_W-1]}}, macc};
            end
            OP_SAD_B: result = DATA_W'(sad_b);
            OP_SAD_H: result = DATA_W'(sad_h);
            default:  result = '0;
        endcase
    end

    assign out_valid = vld_q;

    // R1: a capture yields exactly one valid cycle.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1: no capture, no valid.
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1: result holds between captures.
    a_r1_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R2: reset clears the valid flag.
    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    // R7: unsigned reduction never reaches the upper bits.
    a_r7_maccu_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_MACC_U) |-> (result[DATA_W-1:MACC_W] == '0));
    // R8: byte absolute-difference sum stays in range.
    a_r8_sadb_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_SAD_B) |-> (result[DATA_W-1:SADB_W] == '0));
    // R9: halfword absolute-difference sum stays in range.
    a_r9_sadh_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_SAD_H) |-> (result[DATA_W-1:SADH_W] == '0));
    // R10: unused codes give zero.
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q > OP_LAST) |-> (result == '0));

endmodule

// File: tb/pmul_sad_unit_tb.sv
module pmul_sad_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam int NPAT = 7;
    localparam logic [63:0] PAT [NPAT] = '{
        64'h8000_8000_8000_8000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0000,
        64'h7FFF_7FFF_7FFF_7FFF,
        64'h8000_FFFF_0001_7FFF,
        64'h0123_4567_89AB_CDEF,
        64'hFF00_80FF_0080_7F01
    };

    always #10 clk = ~clk;

    pmul_sad_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd2: return "R3";
            4'd1, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6:       return "R6";
            4'd7:       return "R7";
            4'd8:       return "R8";
            4'd9:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    // Behavioural model written from the requirement text.
    function automatic logic [63:0] ref_model(input logic [3:0] op,
                                              input logic [63:0] a,
                                              input logic [63:0] b);
        logic [63:0] r;
        logic [63:0] t;
        longint p [4];
        longint acc;
        bit sg;
        r   = '0;
        acc = 0;
        sg  = (op == 4'd0) || (op == 4'd1) || (op == 4'd4) || (op == 4'd6);
        for (int i = 0; i < 4; i++) begin
            longint x;
            longint y;
            if (sg) begin
                x = longint'($signed(a[16*i +: 16]));
                y = longint'($signed(b[16*i +: 16]));
            end else begin
                x = longint'(a[16*i +: 16]);
                y = longint'(b[16*i +: 16]);
            end
            p[i] = x * y;
        end
        case (op)
            4'd0, 4'd2: for (int i = 0; i < 4; i++) begin
                t = p[i]; r[16*i +: 16] = t[15:0];
            end
            4'd1, 4'd3: for (int i = 0; i < 4; i++) begin
                t = p[i]; r[16*i +: 16] = t[31:16];
            end
            4'd4, 4'd5: begin
                t = p[0] + p[1]; r[31:0]  = t[31:0];
                t = p[2] + p[3]; r[63:32] = t[31:0];
            end
            4'd6, 4'd7: r = p[0] + p[1] + p[2] + p[3];
            4'd8: begin
                for (int i = 0; i < 8; i++) begin
                    longint ua = longint'(a[8*i +: 8]);
                    longint ub = longint'(b[8*i +: 8]);
                    acc += (ua > ub) ? ua - ub : ub - ua;
                end
                r = acc;
            end
            4'd9: begin
                for (int i = 0; i < 4; i++) begin
                    longint ua = longint'(a[16*i +: 16]);
                    longint ub = longint'(b[16*i +: 16]);
                    acc += (ua > ub) ? ua - ub : ub - ua;
                end
                r = acc;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One capture, then sample one cycle later away from the edge.
    task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", 64'(out_valid), 64'd1);
        check(req_of(op), result, ref_model(op, a, b));
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        // R2: reset holds valid low even with the strobe high.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", 64'(out_valid), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(out_valid), 64'd0);

        // Stimulus table walked against every code.
        for (int ia = 0; ia < NPAT; ia++)
            for (int ib = 0; ib < NPAT; ib++)
                for (int op = 0; op < 16; op++)
                    issue(4'(op), PAT[ia], PAT[ib]);

        // Random operands for every code.
        for (int k = 0; k < 40; k++)
            for (int op = 0; op < 16; op++)
                issue(4'(op), {$urandom, $urandom}, {$urandom, $urandom});

        // R6: negative sum must be sign-extended (4 x (-1 x 32767)).
        issue(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
        check("R6", result, 64'hFFFF_FFFF_FFFE_0004);
        // R7: largest unsigned reduction, 4 x 0xFFFE0001.
        issue(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7", result, 64'h0000_0003_FFF8_0004);
        // R4: signed high half of 0x8000 squared is 0x4000.
        issue(4'd1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        check("R4", result, 64'h4000_4000_4000_4000);
        // R8: larger operand on either side, all bytes differ by 255.
        issue(4'd8, 64'hFF00_FF00_FF00_FF00, 64'h00FF_00FF_00FF_00FF);
        check("R8", result, 64'd2040);
        // R9: maximal halfword difference sum.
        issue(4'd9, 64'h0000_FFFF_0000_FFFF, 64'hFFFF_0000_FFFF_0000);
        check("R9", result, 64'd262140);

        // R1: result holds while inputs change without a strobe.
        issue(4'd2, 64'h0003_0003_0003_0003, 64'h0005_0005_0005_0005);
        held = result;
        @(negedge clk);
        op_code = 4'd9; src_a = '1; src_b = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", result, held);
        check("R1", 64'(out_valid), 64'd0);
        check("R3", held, 64'h000F_000F_000F_000F);

        // R10: an unused code right after a valid one gives zero.
        issue(4'd15, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444);
        check("R10", result, 64'd0);

        // R2: reset asserted during a strobe suppresses valid.
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; op_code = 4'd0;
        @(negedge clk);
        check("R2", 64'(out_valid), 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R2", 64'(out_valid), 64'd0);

        finish_run();
    end

endmodule